// File: doc/BRIEF.md
# Command-to-AXI4 Single-Beat Bridge

This block drains a queue of packed configuration commands and performs each one as a single-beat AXI4 transaction on a 256-bit memory bus. A command word holds a direction flag, a 23-bit row number and a 256-bit payload. A write command produces an address handshake, then a data handshake, then a wait for the write response. A read command produces an address handshake and collects one read beat, which goes into a response queue.

Only one command is handled at a time. The block pops a command only from its idle state. The queue data is captured on the cycle after the pop. The block returns to idle once the final handshake of the transaction completes.

States: `ST_IDLE` (waits for a non-empty queue and pulses the pop), `ST_LATCH` (captures the command and decodes its direction), `ST_AW` (write address valid), `ST_W` (write data valid), `ST_B` (write response ready), `ST_AR` (read address valid) and `ST_R` (read data ready while the response queue has room). Transitions:
- IDLE→LATCH on a non-empty queue.
- LATCH→AW when the flag is 1; LATCH→AR when it is 0.
- AW→W on AWREADY.
- W→B on WREADY.
- B→IDLE on BVALID.
- AR→R on ARREADY.
- R→IDLE on the R handshake.

Top module: `cmd_axi_bridge`

## Requirements
- R1: After reset, and while the command queue is empty, `cmd_rden`, `awvalid`, `wvalid`, `bready`, `arvalid`, `rready` and `rsp_wren` are all low.
- R2: `cmd_rden` is a one-cycle pulse. It is raised only in idle and only while `cmd_empty` is low.
- R3: For a write, `awaddr` is {5'b0, row, 5'b0}, where row is command bits [278:256]. The constant fields are `awlen`=0, `awsize`=5, `awburst`=2'b01, `awid`=0, `wstrb` all ones and `wlast`=1.
- R4: A write presents AW first, then W after the AW handshake, then BREADY after the W handshake. At most one of `awvalid`, `wvalid`, `bready`, `arvalid` and `rready` is high in any cycle.
- R5: Once raised, `awvalid`, `wvalid` and `arvalid` stay high until the matching ready is sampled high. The address or data they carry stays stable meanwhile.
- R6: For a read, `araddr` is {5'b0, row, 5'b0}. The constant fields are `arlen`=0, `arsize`=5, `arburst`=2'b01 and `arid`=0.
- R7: While the read beat is awaited, `rready` is low whenever `rsp_full` is high and high whenever it is low.
- R8: `rsp_wren` is high for exactly the cycle in which `rvalid` and `rready` are both high, and `rsp_din` equals `rdata` in that cycle.
- R9: The cycle after the B handshake or the R handshake, the block is idle with no valid or ready raised. `cmd_rden` stays low for the whole of a transaction even when the queue is non-empty.
- R10: `wdata` equals command bits [255:0].
- R11: Command bit 279 selects a write (1) or a read (0). The word is captured on the cycle after the `cmd_rden` pulse, and later changes of `cmd_dout` have no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_empty | input | 1 | Command queue empty |
| cmd_dout | input | 280 | Command word: flag, row, payload |
| cmd_rden | output | 1 | Command queue pop |
| rsp_full | input | 1 | Response queue full |
| rsp_din | output | 256 | Response data |
| rsp_wren | output | 1 | Response queue push |
| awid | output | 6 | Write ID, zero |
| awaddr | output | 33 | Write byte address |
| awlen | output | 8 | Write beats minus one, zero |
| awsize | output | 3 | Write beat size, 32 bytes |
| awburst | output | 2 | Write burst type, INCR |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 256 | Write data |
| wstrb | output | 32 | Write strobes, all set |
| wlast | output | 1 | Last write beat, always 1 |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| arid | output | 6 | Read ID, zero |
| araddr | output | 33 | Read byte address |
| arlen | output | 8 | Read beats minus one, zero |
| arsize | output | 3 | Read beat size, 32 bytes |
| arburst | output | 2 | Read burst type, INCR |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 256 | Read data |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
The assertions assume a command queue that presents the popped word on the cycle after `cmd_rden` and holds `cmd_empty` honestly. They also assume a subordinate that raises BVALID and RVALID only for a transaction the block has issued. The stimulus plays that role cycle by cycle. It drives the word only in the capture cycle and inverts it afterwards. It raises each ready or response only inside the matching state, and it sweeps every combination of zero to two wait cycles on AWREADY, WREADY and BVALID. Reads sweep address-ready delay against zero to three cycles of a full response queue.

// File: rtl/cab_pkg.sv
package cab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LATCH = 3'd1,
        ST_AW    = 3'd2,
        ST_W     = 3'd3,
        ST_B     = 3'd4,
        ST_AR    = 3'd5,
        ST_R     = 3'd6
    } cab_state_e;

    localparam logic [1:0] CAB_BURST_INCR = 2'b01;

endpackage

// File: rtl/cab_cmd_latch.sv
module cab_cmd_latch #(
    parameter int ROW_W  = 23,
    parameter int DATA_W = 256,
    parameter int ADDR_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] data_out
);
    localparam int OFS_W = $clog2(DATA_W / 8);
    localparam int PAD_W = ADDR_W - ROW_W - OFS_W;

    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            data_q <= '0;
        end else if (latch_en) begin
            row_q  <= row_in;
            data_q <= data_in;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign byte_addr = {{PAD_W{1'b0}}, row_q, {OFS_W{1'b0}}};
        end else begin : g_nopad
            assign byte_addr = {row_q, {OFS_W{1'b0}}};
        end
    endgenerate

    assign data_out = data_q;

endmodule

// File: rtl/cab_fsm.sv
module cab_fsm
    import cab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_empty,
    input  logic cmd_is_write,
    input  logic awready,
    input  logic wready,
    input  logic bvalid,
    input  logic arready,
    input  logic rvalid,
    input  logic rsp_full,
    output logic cmd_rden,
    output logic latch_en,
    output logic awvalid,
    output logic wvalid,
    output logic bready,
    output logic arvalid,
    output logic rready,
    output logic rsp_wren
);
    cab_state_e state_q;
    cab_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cmd_empty) state_d = ST_LATCH;
            ST_LATCH: state_d = cmd_is_write ? ST_AW : ST_AR;
            ST_AW:    if (awready) state_d = ST_W;
            ST_W:     if (wready) state_d = ST_B;
            ST_B:     if (bvalid) state_d = ST_IDLE;
            ST_AR:    if (arready) state_d = ST_R;
            ST_R:     if (rvalid && !rsp_full) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_rden = 1'b0;
        latch_en = 1'b0;
        awvalid  = 1'b0;
        wvalid   = 1'b0;
        bready   = 1'b0;
        arvalid  = 1'b0;
        rready   = 1'b0;
        rsp_wren = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_rden = !cmd_empty;
            ST_LATCH: latch_en = 1'b1;
            ST_AW:    awvalid  = 1'b1;
            ST_W:     wvalid   = 1'b1;
            ST_B:     bready   = 1'b1;
            ST_AR:    arvalid  = 1'b1;
            ST_R: begin
                rready   = !rsp_full;
                rsp_wren = rvalid && !rsp_full;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cmd_axi_bridge.sv
module cmd_axi_bridge #(
    parameter int ROW_W  = 23,
    parameter int DATA_W = 256,
    parameter int ADDR_W = 33,
    parameter int ID_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_empty,
    input  logic [ROW_W+DATA_W:0]   cmd_dout,
    output logic                    cmd_rden,
    input  logic                    rsp_full,
    output logic [DATA_W-1:0]       rsp_din,
    output logic                    rsp_wren,
    output logic [ID_W-1:0]         awid,
    output logic [ADDR_W-1:0]       awaddr,
    output logic [7:0]              awlen,
    output logic [2:0]              awsize,
    output logic [1:0]              awburst,
    output logic                    awvalid,
    input  logic                    awready,
    output logic [DATA_W-1:0]       wdata,
    output logic [DATA_W/8-1:0]     wstrb,
    output logic                    wlast,
    output logic                    wvalid,
    input  logic                    wready,
    input  logic                    bvalid,
    output logic                    bready,
    output logic [ID_W-1:0]         arid,
    output logic [ADDR_W-1:0]       araddr,
    output logic [7:0]              arlen,
    output logic [2:0]              arsize,
    output logic [1:0]              arburst,
    output logic                    arvalid,
    input  logic                    arready,
    input  logic [DATA_W-1:0]       rdata,
    input  logic                    rvalid,
    output logic                    rready
);
    import cab_pkg::*;

    localparam int CMD_W = ROW_W + DATA_W + 1;
    localparam int OFS_W = $clog2(DATA_W / 8);

    logic              latch_en;
    logic [ADDR_W-1:0] byte_addr;

    cab_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_empty    (cmd_empty),
        .cmd_is_write (cmd_dout[CMD_W-1]),
        .awready      (awready),
        .wready       (wready),
        .bvalid       (bvalid),
        .arready      (arready),
        .rvalid       (rvalid),
        .rsp_full     (rsp_full),
        .cmd_rden     (cmd_rden),
        .latch_en     (latch_en),
        .awvalid      (awvalid),
        .wvalid       (wvalid),
        .bready       (bready),
        .arvalid      (arvalid),
        .rready       (rready),
        .rsp_wren     (rsp_wren)
    );

    cab_cmd_latch #(
        .ROW_W  (ROW_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (latch_en),
        .row_in    (cmd_dout[CMD_W-2:DATA_W]),
        .data_in   (cmd_dout[DATA_W-1:0]),
        .byte_addr (byte_addr),
        .data_out  (wdata)
    );

    assign awaddr  = byte_addr;
    assign araddr  = byte_addr;
    assign awid    = '0;
    assign arid    = '0;
    assign awlen   = '0;
    assign arlen   = '0;
    assign awsize  = 3'(OFS_W);
    assign arsize  = 3'(OFS_W);
    assign awburst = CAB_BURST_INCR;
    assign arburst = CAB_BURST_INCR;
    assign wstrb   = '1;
    assign wlast   = 1'b1;
    assign rsp_din = rdata;

endmodule

// File: rtl/cab_checker.sv
module cab_checker #(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 33
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_empty,
    input logic              cmd_rden,
    input logic              rsp_full,
    input logic              rsp_wren,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic              bvalid,
    input logic              bready,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic              rvalid,
    input logic              rready
);
    a_r2_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rden |-> !cmd_empty);

    a_r2_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rden |=> !cmd_rden);

    a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({awvalid, wvalid, bready, arvalid, rready}));

    a_r4_w_after_aw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wvalid) |-> $past(awvalid && awready));

    a_r4_b_after_w: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bready) |-> $past(wvalid && wready));

    a_r5_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

    a_r5_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata)));

    a_r5_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> !rready);

    a_r8_push_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wren |-> (rvalid && rready));

    a_r9_idle_after_b: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && bready) |=> !(awvalid || wvalid || bready || arvalid || rready));

    a_r9_idle_after_r: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready) |=> !(awvalid || wvalid || bready || arvalid || rready));

    a_r9_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || wvalid || bready || arvalid || rready) |-> !cmd_rden);

endmodule

bind cmd_axi_bridge cab_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmd_axi_bridge_test.sv
`timescale 1ns/100ps
module cmd_axi_bridge_test;
    localparam int ROW_W  = 23;
    localparam int DATA_W = 256;
    localparam int ADDR_W = 33;
    localparam int ID_W   = 6;
    localparam int CMD_W  = ROW_W + DATA_W + 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cmd_empty, cmd_rden, rsp_full, rsp_wren;
    logic [CMD_W-1:0] cmd_dout;
    logic [DATA_W-1:0] rsp_din, wdata, rdata;
    logic [ID_W-1:0] awid, arid;
    logic [ADDR_W-1:0] awaddr, araddr;
    logic [7:0] awlen, arlen;
    logic [2:0] awsize, arsize;
    logic [1:0] awburst, arburst;
    logic awvalid, awready, wlast, wvalid, wready, bvalid, bready;
    logic arvalid, arready, rvalid, rready;
    logic [DATA_W/8-1:0] wstrb;

    cmd_axi_bridge uut (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] row_addr(input logic [ROW_W-1:0] row);
        return {5'b0, row, 5'b0};
    endfunction

    task automatic idle_chk(input string tag);
        logic [5:0] v;
        v = {awvalid, wvalid, bready, arvalid, rready, rsp_wren};
        chk(v == 6'b0, tag, DATA_W'(v), '0);
    endtask

    // pops one command; returns just after the negedge in the first AW/AR cycle
    task automatic issue(input logic [CMD_W-1:0] cmd, input logic busy_empty);
        @(negedge clk);
        cmd_empty = 1'b0;
        cmd_dout  = ~cmd;
        #1;
        chk(cmd_rden === 1'b1, "R2 pop in idle", DATA_W'(cmd_rden), 1);
        @(negedge clk);
        cmd_empty = busy_empty;
        cmd_dout  = cmd;
        #1;
        chk(cmd_rden === 1'b0, "R2 pop is one cycle", DATA_W'(cmd_rden), 0);
        @(negedge clk);
        cmd_dout = ~cmd;   // R11: later changes must not matter
    endtask

    task automatic do_write(input logic [ROW_W-1:0] row, input logic [DATA_W-1:0] data,
                            input int daw, input int dw, input int db, input logic busy_empty);
        issue({1'b1, row, data}, busy_empty);
        for (int i = 0; i <= daw; i++) begin
            awready = (i == daw);
            #1;
            chk(awvalid && !wvalid && !bready && !arvalid, "R4 AW phase", DATA_W'({awvalid, wvalid, bready, arvalid}), 4'b1000);
            chk(awaddr == row_addr(row), "R3 R11 awaddr", DATA_W'(awaddr), DATA_W'(row_addr(row)));
            chk(awlen == 0 && awsize == 3'd5 && awburst == 2'b01 && awid == 0, "R3 aw fields",
                DATA_W'({awlen, awsize, awburst, awid}), DATA_W'({8'd0, 3'd5, 2'b01, 6'd0}));
            chk(cmd_rden == 1'b0, "R9 no pop while busy", DATA_W'(cmd_rden), 0);
            @(negedge clk);
        end
        awready = 1'b0;
        for (int i = 0; i <= dw; i++) begin
            wready = (i == dw);
            #1;
            chk(wvalid && !awvalid && !bready, "R4 R5 W phase", DATA_W'({awvalid, wvalid, bready}), 3'b010);
            chk(wdata == data, "R10 R11 wdata", wdata, data);
            chk(wlast == 1'b1 && wstrb == '1, "R3 wlast wstrb", DATA_W'({wlast, wstrb}), DATA_W'({1'b1, 32'hFFFFFFFF}));
            chk(cmd_rden == 1'b0, "R9 no pop while busy", DATA_W'(cmd_rden), 0);
            @(negedge clk);
        end
        wready = 1'b0;
        for (int i = 0; i <= db; i++) begin
            bvalid = (i == db);
            #1;
            chk(bready && !wvalid && !awvalid, "R4 B phase", DATA_W'({awvalid, wvalid, bready}), 3'b001);
            @(negedge clk);
        end
        bvalid    = 1'b0;
        cmd_empty = 1'b1;
        #1;
        idle_chk("R9 idle after B");
    endtask

    task automatic do_read(input logic [ROW_W-1:0] row, input logic [DATA_W-1:0] data,
                           input int dar, input int dfull);
        issue({1'b0, row, ~data}, 1'b1);
        for (int i = 0; i <= dar; i++) begin
            arready = (i == dar);
            #1;
            chk(arvalid && !awvalid && !rready, "R5 R11 AR phase", DATA_W'({arvalid, awvalid, rready}), 3'b100);
            chk(araddr == row_addr(row), "R6 araddr", DATA_W'(araddr), DATA_W'(row_addr(row)));
            chk(arlen == 0 && arsize == 3'd5 && arburst == 2'b01 && arid == 0, "R6 ar fields",
                DATA_W'({arlen, arsize, arburst, arid}), DATA_W'({8'd0, 3'd5, 2'b01, 6'd0}));
            @(negedge clk);
        end
        arready = 1'b0;
        rvalid  = 1'b1;
        rdata   = data;
        for (int i = 0; i < dfull; i++) begin
            rsp_full = 1'b1;
            #1;
            chk(!rready && !rsp_wren, "R7 full holds rready low", DATA_W'({rready, rsp_wren}), 0);
            @(negedge clk);
        end
        rsp_full = 1'b0;
        #1;
        chk(rready && rsp_wren, "R7 R8 push on handshake", DATA_W'({rready, rsp_wren}), 2'b11);
        chk(rsp_din == data, "R8 response data", rsp_din, data);
        @(negedge clk);
        rvalid = 1'b0;
        rdata  = ~data;
        #1;
        idle_chk("R8 R9 idle after R");
    endtask

    initial begin
        rst_n = 1'b0; cmd_empty = 1'b1; cmd_dout = '0; rsp_full = 1'b0;
        awready = 1'b0; wready = 1'b0; bvalid = 1'b0; arready = 1'b0;
        rvalid = 1'b0; rdata = '0;
        repeat (3) @(negedge clk);
        #1;
        idle_chk("R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            idle_chk("R1 idle after reset");
            chk(cmd_rden == 1'b0, "R1 no pop when empty", DATA_W'(cmd_rden), 0);
        end

        begin
            int k;
            k = 0;
            for (int a = 0; a < 3; a++)
                for (int w = 0; w < 3; w++)
                    for (int b = 0; b < 3; b++) begin
                        do_write(23'(k * 104729 + 17), {8{32'(k * 32'h9E3779B1 + 5)}}, a, w, b, 1'(k % 2));
                        k++;
                    end
            for (int a = 0; a < 3; a++)
                for (int f = 0; f < 4; f++) begin
                    do_read(23'(k * 7919 + 1), {8{32'(k * 32'h85EBCA6B + 9)}} ^ {DATA_W{1'b1}}, a, f);
                    k++;
                end
        end

        // boundary rows and payloads
        do_write('1, '1, 0, 0, 0, 1'b0);
        do_write('0, '0, 1, 0, 2, 1'b1);
        do_read('1, {DATA_W/2{2'b10}}, 0, 0);
        do_read('0, '1, 2, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule